// File: doc/BRIEF.md
# Machine-Mode Trap Sequencer with Nested-Trap Guard

This block keeps the machine-level status state of a single RISC-V hart and sequences the two control transfers that involve that state. The first is trap entry. The second is the return from a trap handler (MRET). It owns the status word and its upper half, the exception PC, the cause, the trap value and the trap-vector base. A CSR port reads and writes these registers. A trap request carries a cause code and the faulting PC. An MRET strobe requests the return. Each control transfer produces a registered redirect PC one cycle later.

A guard bit in the upper status half protects against re-entry. Trap entry sets the guard bit and MRET clears it. While the guard is set, software cannot turn on the global interrupt enable. A trap that arrives while the guard is still set does not redirect. Instead it stops the hart: a sticky halt output asserts, and every later trap, MRET and CSR write is ignored until reset. The guard bit comes out of reset set, so software must clear it before the first trap can be taken.

The CSR port also protects the read-only counter and machine-information addresses. It reports accesses to unimplemented addresses. Exception-PC reads are aligned to the instruction alignment that the compressed-ISA enable input selects.

Top module: `mtrap_ctrl`

## Requirements
- R1: After a synchronous reset, the status word (address 0x300) reads 0x0000_1880, which is previous-enable 1 and previous-mode 3. The upper status half (0x310) reads 0x0000_0400, meaning the guard is set and byte order is little. The vector register (0x305), exception PC (0x341), cause (0x342) and trap value (0x343) read 0. `halt`, `redirect_valid` and `irq_en` are 0.
- R2: Status word layout: bit 3 is the interrupt enable, bit 7 is the previous enable, and bits 12:11 are the previous mode, which always read 3. All other bits read 0. A write loads bit 7 into the previous enable. It sets the interrupt enable to written bit 3 only while the guard is 0; otherwise the enable becomes 0. Writes to bits 12:11 are ignored.
- R3: Upper status half layout: bit 5 is big-endian and bit 10 is the guard. All other bits read 0. A write loads both bits. `big_endian` follows bit 5.
- R4: On an accepted trap, the cause register takes `trap_cause`, the exception PC takes `trap_pc`, and the trap value becomes 0. The previous enable takes the old interrupt enable, and the interrupt enable is cleared.
- R5: On an accepted trap while the guard is 0, the guard is set. In the next cycle `redirect_valid` pulses with the handler address on `redirect_pc`.
- R6: The vector register holds the base in bits 31:2 and the mode in bit 0. Bit 1 reads 0. In mode 1, a cause with bit 31 set redirects to base + 4 × cause[30:0]. Every other case redirects to the base.
- R7: An accepted trap while the guard is 1 sets `halt` in the next cycle, with no redirect. The trap state still updates as in R4. `halt` stays set until reset. While it is set, trap requests, MRET and CSR writes have no effect.
- R8: An accepted MRET redirects in the next cycle to the masked exception PC (R9). It copies the previous enable into the interrupt enable, sets the previous enable to 1 and clears the guard.
- R9: Exception PC reads, and the MRET target, have bit 0 forced to 0. Bit 1 is also forced to 0 when `rvc_en` is 0. The stored value keeps all bits.
- R10: A write to 0xC00–0xC02, 0xC80–0xC82 or 0xF11–0xF15 sets `csr_fault` in the next cycle and changes nothing. A read of those addresses returns 0 with no fault.
- R11: A read or write to any address that is neither implemented nor listed in R10 sets `csr_fault` in the next cycle and changes nothing.
- R12: When requests coincide in a cycle, a trap wins over MRET, and MRET wins over a CSR write. The losing requests have no effect.
- R13: `csr_rdata` and `csr_fault` are registered. They reflect the access presented one cycle earlier, using the state from before that cycle's updates. Both are 0 when no access was presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rvc_en | input | 1 | Compressed instructions enabled (2-byte PC alignment) |
| csr_en | input | 1 | CSR access presented this cycle |
| csr_we | input | 1 | Access is a write |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | Registered read data |
| csr_fault | output | 1 | Registered illegal-access flag (cause 2 to the core) |
| trap_req | input | 1 | Trap request |
| trap_cause | input | 32 | Trap cause; bit 31 marks an interrupt |
| trap_pc | input | 32 | PC of the trapping instruction |
| mret_req | input | 1 | MRET request |
| redirect_valid | output | 1 | One-cycle pulse: fetch from redirect_pc |
| redirect_pc | output | 32 | Redirect target, 0 when not valid |
| halt | output | 1 | Sticky halt after a nested trap |
| irq_en | output | 1 | Current interrupt enable |
| big_endian | output | 1 | Current data byte order |

## Verification
Some behaviours are checked by the assertions on every cycle: the halt bit is sticky and never comes with a redirect, an accepted trap clears the enable and sets the guard, an accepted MRET redirects and drops the guard, a status write under the guard cannot raise the enable, the previous mode always reads 3, the reserved bits of the upper half read 0, and a counter write faults. Other behaviours can only be shown by the bench's scenarios against its reference model. These are the exact handler address in each vector mode, the exception-PC alignment under both settings of the compressed enable, the arbitration when trap, MRET and write coincide, and the proof that a halted hart leaves every register unchanged.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;
  localparam int XLEN    = 32;
  localparam int CSR_AW  = 12;

  localparam logic [CSR_AW-1:0] A_STAT   = 12'h300;
  localparam logic [CSR_AW-1:0] A_STATH  = 12'h310;
  localparam logic [CSR_AW-1:0] A_TVEC   = 12'h305;
  localparam logic [CSR_AW-1:0] A_EPC    = 12'h341;
  localparam logic [CSR_AW-1:0] A_CAUSE  = 12'h342;
  localparam logic [CSR_AW-1:0] A_TVAL   = 12'h343;

  // bit positions decoded by software
  localparam int B_IE    = 3;
  localparam int B_PIE   = 7;
  localparam int B_PPLO  = 11;
  localparam int B_PPHI  = 12;
  localparam int B_BE    = 5;
  localparam int B_GUARD = 10;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_STAT, SEL_STATH, SEL_TVEC, SEL_EPC, SEL_CAUSE, SEL_TVAL
  } csr_sel_e;

  function automatic logic addr_readonly(input logic [CSR_AW-1:0] a);
    return ((a >= 12'hC00) && (a <= 12'hC02)) ||
           ((a >= 12'hC80) && (a <= 12'hC82)) ||
           ((a >= 12'hF11) && (a <= 12'hF15));
  endfunction

  function automatic csr_sel_e addr_decode(input logic [CSR_AW-1:0] a);
    case (a)
      A_STAT:  return SEL_STAT;
      A_STATH: return SEL_STATH;
      A_TVEC:  return SEL_TVEC;
      A_EPC:   return SEL_EPC;
      A_CAUSE: return SEL_CAUSE;
      A_TVAL:  return SEL_TVAL;
      default: return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/mtrap_status.sv
module mtrap_status (
  input  logic        clk,
  input  logic        rst,
  input  logic        trap_take,
  input  logic        mret_take,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [31:0] wdata,
  output logic        ie_q,
  output logic        pie_q,
  output logic        guard_q,
  output logic        be_q
);
  import mtrap_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q    <= 1'b0;
      pie_q   <= 1'b1;
      guard_q <= 1'b1;
      be_q    <= 1'b0;
    end else if (trap_take) begin
      pie_q   <= ie_q;
      ie_q    <= 1'b0;
      guard_q <= 1'b1;
    end else if (mret_take) begin
      ie_q    <= pie_q;
      pie_q   <= 1'b1;
      guard_q <= 1'b0;
    end else begin
      if (wr_lo) begin
        ie_q  <= wdata[B_IE] & ~guard_q;
        pie_q <= wdata[B_PIE];
      end
      if (wr_hi) begin
        be_q    <= wdata[B_BE];
        guard_q <= wdata[B_GUARD];
      end
    end
  end
endmodule

// File: rtl/mtrap_regs.sv
module mtrap_regs #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         trap_take,
  input  logic [W-1:0] trap_cause,
  input  logic [W-1:0] trap_pc,
  input  logic         wr_epc,
  input  logic         wr_cause,
  input  logic         wr_tval,
  input  logic         wr_tvec,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] epc_q,
  output logic [W-1:0] cause_q,
  output logic [W-1:0] tval_q,
  output logic [W-3:0] tbase_q,
  output logic         tmode_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      epc_q   <= '0;
      cause_q <= '0;
      tval_q  <= '0;
      tbase_q <= '0;
      tmode_q <= 1'b0;
    end else if (trap_take) begin
      epc_q   <= trap_pc;
      cause_q <= trap_cause;
      tval_q  <= '0;
    end else begin
      if (wr_epc)   epc_q   <= wdata;
      if (wr_cause) cause_q <= wdata;
      if (wr_tval)  tval_q  <= wdata;
      if (wr_tvec) begin
        tbase_q <= wdata[W-1:2];
        tmode_q <= wdata[0];
      end
    end
  end
endmodule

// File: rtl/mtrap_target.sv
module mtrap_target #(
  parameter int W         = 32,
  parameter bit VEC_EN    = 1'b1,
  parameter int SLOT_LOG2 = 2
) (
  input  logic [W-3:0] tbase,
  input  logic         tmode,
  input  logic [W-1:0] cause,
  output logic [W-1:0] target
);
  logic [W-1:0] base_addr;
  assign base_addr = {tbase, 2'b00};

  generate
    if (VEC_EN) begin : g_vec
      logic [W-1:0] code;
      logic [W-1:0] offs;
      assign code = {1'b0, cause[W-2:0]};
      assign offs = code << SLOT_LOG2;
      always_comb begin
        if (tmode && cause[W-1]) target = base_addr + offs;
        else                     target = base_addr;
      end
    end else begin : g_direct
      logic unused_ok;
      assign unused_ok = tmode ^ (^cause);
      assign target = base_addr;
    end
  endgenerate
endmodule

// File: rtl/mtrap_ctrl.sv
module mtrap_ctrl #(
  parameter int XW = mtrap_pkg::XLEN,
  parameter int AW = mtrap_pkg::CSR_AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rvc_en,
  input  logic          csr_en,
  input  logic          csr_we,
  input  logic [AW-1:0] csr_addr,
  input  logic [XW-1:0] csr_wdata,
  output logic [XW-1:0] csr_rdata,
  output logic          csr_fault,
  input  logic          trap_req,
  input  logic [XW-1:0] trap_cause,
  input  logic [XW-1:0] trap_pc,
  input  logic          mret_req,
  output logic          redirect_valid,
  output logic [XW-1:0] redirect_pc,
  output logic          halt,
  output logic          irq_en,
  output logic          big_endian
);
  import mtrap_pkg::*;

  logic          halt_q;
  logic          ie_w, pie_w, guard_w, be_w;
  logic [XW-1:0] epc_w, cause_w, tval_w, target_w, epc_rd;
  logic [XW-3:0] tbase_w;
  logic          tmode_w;
  csr_sel_e      sel;
  logic          ro, impl, bad_c;
  logic          live, trap_take, mret_take, wr_ok;
  logic [XW-1:0] rd_c;

  assign sel  = addr_decode(csr_addr);
  assign ro   = addr_readonly(csr_addr);
  assign impl = (sel != SEL_NONE);
  assign bad_c = csr_en & ((csr_we & ro) | (~ro & ~impl));

  assign live      = ~halt_q;
  assign trap_take = live & trap_req;
  assign mret_take = live & ~trap_req & mret_req;
  assign wr_ok     = live & ~trap_req & ~mret_req & csr_en & csr_we & impl;

  mtrap_status u_status (
    .clk       (clk),
    .rst       (rst),
    .trap_take (trap_take),
    .mret_take (mret_take),
    .wr_lo     (wr_ok && sel == SEL_STAT),
    .wr_hi     (wr_ok && sel == SEL_STATH),
    .wdata     (csr_wdata),
    .ie_q      (ie_w),
    .pie_q     (pie_w),
    .guard_q   (guard_w),
    .be_q      (be_w)
  );

  mtrap_regs #(.W(XW)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .trap_take  (trap_take),
    .trap_cause (trap_cause),
    .trap_pc    (trap_pc),
    .wr_epc     (wr_ok && sel == SEL_EPC),
    .wr_cause   (wr_ok && sel == SEL_CAUSE),
    .wr_tval    (wr_ok && sel == SEL_TVAL),
    .wr_tvec    (wr_ok && sel == SEL_TVEC),
    .wdata      (csr_wdata),
    .epc_q      (epc_w),
    .cause_q    (cause_w),
    .tval_q     (tval_w),
    .tbase_q    (tbase_w),
    .tmode_q    (tmode_w)
  );

  mtrap_target #(.W(XW), .VEC_EN(1'b1), .SLOT_LOG2(2)) u_target (
    .tbase  (tbase_w),
    .tmode  (tmode_w),
    .cause  (trap_cause),
    .target (target_w)
  );

  assign epc_rd = {epc_w[XW-1:2], epc_w[1] & rvc_en, 1'b0};

  always_comb begin
    rd_c = '0;
    case (sel)
      SEL_STAT: begin
        rd_c[B_IE]   = ie_w;
        rd_c[B_PIE]  = pie_w;
        rd_c[B_PPLO] = 1'b1;
        rd_c[B_PPHI] = 1'b1;
      end
      SEL_STATH: begin
        rd_c[B_BE]    = be_w;
        rd_c[B_GUARD] = guard_w;
      end
      SEL_TVEC:  rd_c = {tbase_w, 1'b0, tmode_w};
      SEL_EPC:   rd_c = epc_rd;
      SEL_CAUSE: rd_c = cause_w;
      SEL_TVAL:  rd_c = tval_w;
      default:   rd_c = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      halt_q         <= 1'b0;
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
      csr_rdata      <= '0;
      csr_fault      <= 1'b0;
    end else begin
      csr_rdata <= csr_en ? rd_c : '0;
      csr_fault <= bad_c;
      if (trap_take && guard_w) begin
        halt_q         <= 1'b1;
        redirect_valid <= 1'b0;
        redirect_pc    <= '0;
      end else if (trap_take) begin
        redirect_valid <= 1'b1;
        redirect_pc    <= target_w;
      end else if (mret_take) begin
        redirect_valid <= 1'b1;
        redirect_pc    <= epc_rd;
      end else begin
        redirect_valid <= 1'b0;
        redirect_pc    <= '0;
      end
    end
  end

  assign halt       = halt_q;
  assign irq_en     = ie_w;
  assign big_endian = be_w;
endmodule

// File: rtl/mtrap_ctrl_chk.sv
module mtrap_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic        csr_en,
  input logic        csr_we,
  input logic [11:0] csr_addr,
  input logic [31:0] csr_rdata,
  input logic        csr_fault,
  input logic        trap_req,
  input logic        mret_req,
  input logic        redirect_valid,
  input logic        halt,
  input logic        irq_en,
  input logic        guard
);
  p_halt_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    halt |=> halt);
  p_halt_no_redirect_r7: assert property (@(posedge clk) disable iff (rst)
    halt |-> !redirect_valid);
  p_trap_clears_ie_r4: assert property (@(posedge clk) disable iff (rst)
    (trap_req && !halt) |=> !irq_en);
  p_trap_sets_guard_r5: assert property (@(posedge clk) disable iff (rst)
    (trap_req && !halt) |=> guard);
  p_mret_redirect_r8: assert property (@(posedge clk) disable iff (rst)
    (mret_req && !trap_req && !halt) |=> (redirect_valid && !guard));
  p_guard_blocks_ie_r2: assert property (@(posedge clk) disable iff (rst)
    (csr_en && csr_we && csr_addr == 12'h300 && !trap_req && !mret_req && !halt && guard)
      |=> !irq_en);
  p_prev_mode_r2: assert property (@(posedge clk) disable iff (rst)
    (csr_en && csr_addr == 12'h300) |=> (csr_rdata[12:11] == 2'b11));
  p_upper_reserved_r3: assert property (@(posedge clk) disable iff (rst)
    (csr_en && csr_addr == 12'h310) |=> ((csr_rdata & ~32'h0000_0420) == 32'h0));
  p_counter_write_fault_r10: assert property (@(posedge clk) disable iff (rst)
    (csr_en && csr_we && csr_addr == 12'hC00) |=> csr_fault);
endmodule

bind mtrap_ctrl mtrap_ctrl_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .csr_en         (csr_en),
  .csr_we         (csr_we),
  .csr_addr       (csr_addr),
  .csr_rdata      (csr_rdata),
  .csr_fault      (csr_fault),
  .trap_req       (trap_req),
  .mret_req       (mret_req),
  .redirect_valid (redirect_valid),
  .halt           (halt),
  .irq_en         (irq_en),
  .guard          (guard_w)
);

// File: tb/mtrap_ctrl_bench.sv
module mtrap_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rvc_en = 1'b1;
  logic        csr_en = 1'b0, csr_we = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        csr_fault;
  logic        trap_req = 1'b0;
  logic [31:0] trap_cause = '0, trap_pc = '0;
  logic        mret_req = 1'b0;
  logic        redirect_valid;
  logic [31:0] redirect_pc;
  logic        halt, irq_en, big_endian;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // reference state
  bit          m_ie, m_pie, m_guard, m_be, m_halt, m_mode;
  logic [31:0] m_base, m_epc, m_cause, m_tval;

  always #2 clk = ~clk;

  mtrap_ctrl u_mtrap_ctrl (
    .clk(clk), .rst(rst), .rvc_en(rvc_en),
    .csr_en(csr_en), .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .csr_fault(csr_fault),
    .trap_req(trap_req), .trap_cause(trap_cause), .trap_pc(trap_pc),
    .mret_req(mret_req), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .halt(halt), .irq_en(irq_en), .big_endian(big_endian)
  );

  function automatic bit f_ro(input logic [11:0] a);
    return (a >= 12'hC00 && a <= 12'hC02) || (a >= 12'hC80 && a <= 12'hC82) ||
           (a >= 12'hF11 && a <= 12'hF15);
  endfunction
  function automatic bit f_impl(input logic [11:0] a);
    return a == 12'h300 || a == 12'h310 || a == 12'h305 ||
           a == 12'h341 || a == 12'h342 || a == 12'h343;
  endfunction
  function automatic logic [31:0] f_epc_rd();
    return {m_epc[31:2], m_epc[1] & rvc_en, 1'b0};
  endfunction
  function automatic logic [31:0] f_read(input logic [11:0] a);
    case (a)
      12'h300: return 32'h1800 | (32'(m_pie) << 7) | (32'(m_ie) << 3);
      12'h310: return (32'(m_guard) << 10) | (32'(m_be) << 5);
      12'h305: return m_base | 32'(m_mode);
      12'h341: return f_epc_rd();
      12'h342: return m_cause;
      12'h343: return m_tval;
      default: return 32'h0;
    endcase
  endfunction
  function automatic logic [31:0] f_target(input logic [31:0] c);
    if (m_mode && c[31]) return m_base + ({1'b0, c[30:0]} << 2);
    return m_base;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ie = 0; m_pie = 1; m_guard = 1; m_be = 0; m_halt = 0; m_mode = 0;
    m_base = 0; m_epc = 0; m_cause = 0; m_tval = 0;
  endtask

  // one cycle: drive, predict, compare, advance the model
  task automatic step(input string tag, input bit en, input bit we, input logic [11:0] a,
                      input logic [31:0] wd, input bit tr, input logic [31:0] tc,
                      input logic [31:0] tp, input bit mr);
    bit e_fault, e_rv, e_halt, live, wr;
    logic [31:0] e_rd, e_pc;
    @(negedge clk);
    csr_en = en; csr_we = we; csr_addr = a; csr_wdata = wd;
    trap_req = tr; trap_cause = tc; trap_pc = tp; mret_req = mr;
    live = !m_halt;
    e_rd = en ? f_read(a) : 32'h0;
    e_fault = en && ((we && f_ro(a)) || (!f_ro(a) && !f_impl(a)));
    e_rv = 0; e_pc = 0; e_halt = m_halt;
    wr = live && !tr && !mr && en && we && f_impl(a);
    if (live && tr) begin
      if (m_guard) e_halt = 1;
      else begin e_rv = 1; e_pc = f_target(tc); end
    end else if (live && mr) begin
      e_rv = 1; e_pc = f_epc_rd();
    end
    @(posedge clk);
    #1;
    chk({tag, " R13 rdata"}, csr_rdata, e_rd);
    chk({tag, " R10/R11 fault"}, 32'(csr_fault), 32'(e_fault));
    chk({tag, " R5/R8 redirect_valid"}, 32'(redirect_valid), 32'(e_rv));
    chk({tag, " R6/R9 redirect_pc"}, redirect_pc, e_pc);
    chk({tag, " R7 halt"}, 32'(halt), 32'(e_halt));
    // advance the model
    if (live && tr) begin
      m_epc = tp; m_cause = tc; m_tval = 0;
      m_pie = m_ie; m_ie = 0; m_guard = 1;
    end else if (live && mr) begin
      m_ie = m_pie; m_pie = 1; m_guard = 0;
    end else if (wr) begin
      case (a)
        12'h300: begin m_ie = wd[3] & !m_guard; m_pie = wd[7]; end
        12'h310: begin m_be = wd[5]; m_guard = wd[10]; end
        12'h305: begin m_base = {wd[31:2], 2'b00}; m_mode = wd[0]; end
        12'h341: m_epc = wd;
        12'h342: m_cause = wd;
        12'h343: m_tval = wd;
        default: ;
      endcase
    end
    m_halt = e_halt;
    chk({tag, " R2 irq_en"}, 32'(irq_en), 32'(m_ie));
    chk({tag, " R3 big_endian"}, 32'(big_endian), 32'(m_be));
  endtask

  task automatic rd(input string tag, input logic [11:0] a);
    step(tag, 1, 0, a, 0, 0, 0, 0, 0);
  endtask
  task automatic wr(input string tag, input logic [11:0] a, input logic [31:0] d);
    step(tag, 1, 1, a, d, 0, 0, 0, 0);
  endtask
  task automatic trap(input string tag, input logic [31:0] c, input logic [31:0] p);
    step(tag, 0, 0, 0, 0, 1, c, p, 0);
  endtask
  task automatic mret(input string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 0, 1);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    chk("R1 halt", 32'(halt), 0);
    chk("R1 redirect", 32'(redirect_valid), 0);
    chk("R1 irq_en", 32'(irq_en), 0);
    // R1 reset images
    rd("R1 stat", 12'h300); chk("R1 stat value", csr_rdata, 32'h1880);
    rd("R1 stath", 12'h310); chk("R1 stath value", csr_rdata, 32'h400);
    rd("R1 tvec", 12'h305); rd("R1 epc", 12'h341);
    rd("R1 cause", 12'h342); rd("R1 tval", 12'h343);
    // R2 enable blocked by guard
    wr("R2 guarded write", 12'h300, 32'h0000_0008); rd("R2 readback", 12'h300);
    chk("R2 guard blocks enable", csr_rdata, 32'h1800);
    // R3 clear guard, then R2 full write
    wr("R3 clear guard", 12'h310, 32'h0);
    wr("R2 write all ones", 12'h300, 32'hFFFF_FFFF); rd("R2 readback", 12'h300);
    chk("R2 mask and prev mode", csr_rdata, 32'h1888);
    wr("R3 set order", 12'h310, 32'hFFFF_FBFF); rd("R3 readback", 12'h310);
    chk("R3 mask", csr_rdata, 32'h20);
    // R6 vectored interrupt
    wr("R6 tvec", 12'h305, 32'h1000_0003); rd("R6 tvec readback", 12'h305);
    chk("R6 tvec bit1 zero", csr_rdata, 32'h1000_0001);
    wr("R4 tval preset", 12'h343, 32'hDEAD_BEEF);
    trap("R5 R6 vectored irq", 32'h8000_0007, 32'h0000_0200);
    chk("R6 vector target", redirect_pc, 32'h1000_001C);
    rd("R4 cause", 12'h342); rd("R4 epc", 12'h341); rd("R4 tval", 12'h343);
    rd("R4 stat", 12'h300); chk("R4 pie took ie", csr_rdata, 32'h1880);
    // R8 return
    mret("R8 return"); chk("R8 target", redirect_pc, 32'h200);
    // R6 exception to base, R9 masking
    trap("R6 exception base", 32'h2, 32'h0000_0303);
    chk("R6 base target", redirect_pc, 32'h1000_0000);
    rd("R9 epc rvc on", 12'h341); chk("R9 mask bit0", csr_rdata, 32'h302);
    rvc_en = 0;
    rd("R9 epc rvc off", 12'h341); chk("R9 mask bits1:0", csr_rdata, 32'h300);
    mret("R9 R8 return aligned"); chk("R9 mret target", redirect_pc, 32'h300);
    rvc_en = 1;
    // R10, R11
    wr("R10 counter write", 12'hC00, 32'h5); wr("R10 info write", 12'hF13, 32'h5);
    rd("R10 info read", 12'hF11); chk("R10 no fault", 32'(csr_fault), 0);
    rd("R11 unknown read", 12'h7C0); wr("R11 unknown write", 12'h7C0, 32'h1);
    // R12 arbitration
    step("R12 trap beats mret and write", 1, 1, 12'h342, 32'h77, 1, 32'h5, 32'h440, 1);
    rd("R12 cause kept", 12'h342); chk("R12 cause", csr_rdata, 32'h5);
    step("R12 mret beats write", 1, 1, 12'h341, 32'h999, 0, 0, 0, 1);
    rd("R12 epc kept", 12'h341); chk("R12 epc", csr_rdata, 32'h440);
    // random phase
    for (int i = 0; i < 400; i++) begin
      logic [11:0] a;
      int k;
      bit t, m;
      k = $urandom_range(0, 7);
      case (k)
        0: a = 12'h300; 1: a = 12'h310; 2: a = 12'h305; 3: a = 12'h341;
        4: a = 12'h342; 5: a = 12'h343; 6: a = 12'hC81; default: a = 12'h123;
      endcase
      t = (!m_guard) && ($urandom_range(0, 7) == 0);
      m = ($urandom_range(0, 7) == 0);
      rvc_en = $urandom_range(0, 1);
      step("R12 random", $urandom_range(0, 1), $urandom_range(0, 1), a, $urandom(),
           t, {$urandom_range(0, 1) == 1, 26'h0, 5'($urandom())}, $urandom(), m);
    end
    // R7 nested trap halts
    mret("R7 clear guard");
    trap("R7 first trap", 32'hB, 32'h1000);
    trap("R7 nested trap", 32'h3, 32'h2000);
    chk("R7 halted", 32'(halt), 1);
    trap("R7 ignored trap", 32'h4, 32'h3000);
    mret("R7 ignored mret");
    wr("R7 ignored write", 12'h342, 32'hABCD);
    rd("R7 cause frozen", 12'h342); chk("R7 cause", csr_rdata, 32'h3);
    rd("R7 epc frozen", 12'h341); chk("R7 epc", csr_rdata, 32'h2000);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule